// File: doc/BRIEF.md
# Interval Timer with Halfword Register Bus

This block is a 32-bit down-counting interval timer that software drives through six halfword registers on a simple synchronous write/read bus. Software writes a period value in two halves, then uses a control register to set the interrupt enable and the reload mode, and to pulse start or stop. The counter runs from the programmed value down to zero, so the interval is one cycle longer than the number written. On reaching zero it sets a sticky timeout flag. The flag drives the interrupt request when interrupts are enabled.

In continuous mode the counter reloads and keeps running, which gives a periodic tick. In one-shot mode it reloads and halts after the first timeout. Any write to the status register clears the flag. Because a 32-bit count cannot be read coherently as two halfwords while it moves, a write to the low snapshot offset freezes the whole count into a holding pair that software then reads at leisure.

Read data is registered. The value for the offset presented in one cycle appears on `rdata` after the next rising edge.

Top module: `ivt_timer`

## Requirements
- R1: After reset the counter is stopped, both period halves read 0xFFFF, the count equals the period (0xFFFFFFFF), the control and status registers read 0, the snapshot pair reads 0 and `irq` is low.
- R2: Byte offsets are: 0 status, 4 control, 8 period low, 12 period high, 16 snapshot low, 20 snapshot high. Control bit 0 is the interrupt enable, bit 1 selects continuous mode, bit 2 is the start strobe and bit 3 is the stop strobe. Status bit 0 is the sticky timeout flag and bit 1 shows that the counter is running. Strobe bits and all unused bits read as 0.
- R3: While running, the count decrements by one per cycle. With period value P, the timeout flag is set P+1 cycles after the start write.
- R4: In continuous mode a timeout reloads the count from the period and counting continues, so later timeouts follow every P+1 cycles.
- R5: In one-shot mode (control bit 1 clear) a timeout reloads the count from the period and stops the counter.
- R6: A stop strobe halts counting and keeps the count. A later start strobe resumes from the held count.
- R7: A control write with both start and stop set leaves the counter stopped.
- R8: A write to either period half stops the counter and loads the count with the new 32-bit period.
- R9: Any write to offset 16 captures the count held before that write's clock edge into the snapshot pair. Reads at offsets 16 and 20 return its low and high halves until the next capture.
- R10: Any write to offset 0 clears the timeout flag, unless a timeout occurs in the same cycle, in which case the flag stays set.
- R11: `irq` is high exactly when the timeout flag and the interrupt enable are both set, and it follows either of them one cycle after the write or timeout that changes it.
- R12: `rdata` shows, one cycle later, the register selected by `addr`. Offsets that are not mapped read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the halfword on `wdata` at `addr` |
| addr | input | ADDR_W (5) | Byte offset of the register |
| wdata | input | DATA_W (16) | Write data |
| rdata | output | DATA_W (16) | Registered read data for the previous cycle's `addr` |
| irq | output | 1 | Interrupt request, registered |

## Verification
The counting path is exercised with period values of zero, where every running cycle is a timeout, and with small and mid-range values. These tell apart an off-by-one interval length, a missing reload and a wrong reload source. Directed stop/start, combined-strobe and period-rewrite sequences separate hold-and-resume from restart-from-period, and show that stop has priority over start. A status clear issued in the same cycle as a timeout shows whether the new event is kept. A long random mix of control, period, status, snapshot and read accesses, including unmapped offsets, is compared cycle by cycle with a bench model. This exposes any priority mix-up between bus writes and the counter's own reload.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  // register byte offsets
  localparam int unsigned OFS_STATUS  = 0;
  localparam int unsigned OFS_CTRL    = 4;
  localparam int unsigned OFS_PER_LO  = 8;
  localparam int unsigned OFS_PER_HI  = 12;
  localparam int unsigned OFS_SNAP_LO = 16;
  localparam int unsigned OFS_SNAP_HI = 20;
  // control bit positions
  localparam int CB_IRQ_EN = 0;
  localparam int CB_CONT   = 1;
  localparam int CB_START  = 2;
  localparam int CB_STOP   = 3;
  localparam int CTRL_BITS = 4;
  // status bit positions
  localparam int SB_TIMEOUT = 0;
  localparam int SB_RUN     = 1;
endpackage

// File: rtl/ivt_counter.sv
module ivt_counter #(
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            ld_half_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic                  start_i,
  input  logic                  stop_i,
  input  logic                  cont_i,
  output logic [2*DATA_W-1:0]   cnt_o,
  output logic [2*DATA_W-1:0]   period_o,
  output logic                  run_o,
  output logic                  timeout_o
);
  localparam int CNT_W  = 2 * DATA_W;
  localparam int HALVES = 2;

  logic [CNT_W-1:0] period_q, cnt_q, per_nxt;
  logic             run_q, load;

  always_comb begin
    per_nxt = period_q;
    for (int h = 0; h < HALVES; h++) begin
      if (ld_half_i[h]) per_nxt[h*DATA_W +: DATA_W] = wdata_i;
    end
  end

  assign load      = |ld_half_i;
  assign timeout_o = run_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '1;
      cnt_q    <= '1;
      run_q    <= 1'b0;
    end else if (load) begin
      period_q <= per_nxt;
      cnt_q    <= per_nxt;
      run_q    <= 1'b0;
    end else begin
      if (run_q) begin
        if (cnt_q == '0) begin
          cnt_q <= period_q;
          run_q <= cont_i;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
      if (stop_i)       run_q <= 1'b0;
      else if (start_i) run_q <= 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign period_o = period_q;
  assign run_o    = run_q;

  assert_decrement_R3: assert property (@(posedge clk) disable iff (rst)
    (run_q && cnt_q != '0 && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_reload_R4: assert property (@(posedge clk) disable iff (rst)
    (timeout_o && !load) |=> (cnt_q == $past(period_q)));
  assert_oneshot_halt_R5: assert property (@(posedge clk) disable iff (rst)
    (timeout_o && !cont_i && !start_i && !load) |=> !run_q);
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !load) |=> $stable(cnt_q));
  assert_start_R6: assert property (@(posedge clk) disable iff (rst)
    (start_i && !stop_i && !load) |=> run_q);
  assert_stop_R7: assert property (@(posedge clk) disable iff (rst)
    (stop_i && !load) |=> !run_q);
  assert_load_R8: assert property (@(posedge clk) disable iff (rst)
    load |=> (!run_q && cnt_q == period_q));
endmodule

// File: rtl/ivt_ctrl.sv
module ivt_ctrl (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ctrl_wr_i,
  input  logic                       status_wr_i,
  input  logic [ivt_pkg::CTRL_BITS-1:0] ctrl_bits_i,
  input  logic                       timeout_i,
  output logic                       irq_en_o,
  output logic                       cont_o,
  output logic                       to_o,
  output logic                       start_o,
  output logic                       stop_o,
  output logic                       irq_o
);
  import ivt_pkg::*;

  logic irq_en_q, cont_q, to_q, irq_q;
  logic to_nxt, irq_en_nxt;

  assign stop_o  = ctrl_wr_i && ctrl_bits_i[CB_STOP];
  assign start_o = ctrl_wr_i && ctrl_bits_i[CB_START] && !ctrl_bits_i[CB_STOP];

  always_comb begin
    to_nxt = to_q;
    if (timeout_i)        to_nxt = 1'b1;
    else if (status_wr_i) to_nxt = 1'b0;
    irq_en_nxt = ctrl_wr_i ? ctrl_bits_i[CB_IRQ_EN] : irq_en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_en_q <= 1'b0;
      cont_q   <= 1'b0;
      to_q     <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      irq_en_q <= irq_en_nxt;
      if (ctrl_wr_i) cont_q <= ctrl_bits_i[CB_CONT];
      to_q     <= to_nxt;
      irq_q    <= to_nxt && irq_en_nxt;
    end
  end

  assign irq_en_o = irq_en_q;
  assign cont_o   = cont_q;
  assign to_o     = to_q;
  assign irq_o    = irq_q;

  assert_timeout_sets_R3: assert property (@(posedge clk) disable iff (rst)
    timeout_i |=> to_q);
  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (status_wr_i && !timeout_i) |=> (!to_q && !irq_q));
  assert_irq_needs_flag_R11: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (to_q && irq_en_q));
endmodule

// File: rtl/ivt_snapshot.sv
module ivt_snapshot #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] snap_o
);
  logic [CNT_W-1:0] snap_q;

  always_ff @(posedge clk) begin
    if (rst)        snap_q <= '0;
    else if (cap_i) snap_q <= cnt_i;
  end

  assign snap_o = snap_q;

  assert_capture_R9: assert property (@(posedge clk) disable iff (rst)
    cap_i |=> (snap_q == $past(cnt_i)));
  assert_keep_R9: assert property (@(posedge clk) disable iff (rst)
    !cap_i |=> $stable(snap_q));
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  import ivt_pkg::*;

  localparam int CNT_W = 2 * DATA_W;

  logic             sel_status, sel_ctrl, sel_plo, sel_phi, sel_slo, sel_shi, sel_any;
  logic [CNT_W-1:0] cnt, period, snap;
  logic             run, timeout, irq_en, cont, to_flag, start, stop;
  logic [DATA_W-1:0] rd_nxt, rdata_q;

  assign sel_status = (addr == ADDR_W'(OFS_STATUS));
  assign sel_ctrl   = (addr == ADDR_W'(OFS_CTRL));
  assign sel_plo    = (addr == ADDR_W'(OFS_PER_LO));
  assign sel_phi    = (addr == ADDR_W'(OFS_PER_HI));
  assign sel_slo    = (addr == ADDR_W'(OFS_SNAP_LO));
  assign sel_shi    = (addr == ADDR_W'(OFS_SNAP_HI));
  assign sel_any    = sel_status | sel_ctrl | sel_plo | sel_phi | sel_slo | sel_shi;

  ivt_counter #(.DATA_W(DATA_W)) u_counter (
    .clk       (clk),
    .rst       (rst),
    .ld_half_i ({wr_en && sel_phi, wr_en && sel_plo}),
    .wdata_i   (wdata),
    .start_i   (start),
    .stop_i    (stop),
    .cont_i    (cont),
    .cnt_o     (cnt),
    .period_o  (period),
    .run_o     (run),
    .timeout_o (timeout)
  );

  ivt_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .ctrl_wr_i   (wr_en && sel_ctrl),
    .status_wr_i (wr_en && sel_status),
    .ctrl_bits_i (wdata[CTRL_BITS-1:0]),
    .timeout_i   (timeout),
    .irq_en_o    (irq_en),
    .cont_o      (cont),
    .to_o        (to_flag),
    .start_o     (start),
    .stop_o      (stop),
    .irq_o       (irq)
  );

  ivt_snapshot #(.CNT_W(CNT_W)) u_snapshot (
    .clk    (clk),
    .rst    (rst),
    .cap_i  (wr_en && sel_slo),
    .cnt_i  (cnt),
    .snap_o (snap)
  );

  always_comb begin
    rd_nxt = '0;
    if (sel_status) begin
      rd_nxt[SB_TIMEOUT] = to_flag;
      rd_nxt[SB_RUN]     = run;
    end
    if (sel_ctrl) begin
      rd_nxt[CB_IRQ_EN] = irq_en;
      rd_nxt[CB_CONT]   = cont;
    end
    if (sel_plo) rd_nxt = period[DATA_W-1:0];
    if (sel_phi) rd_nxt = period[CNT_W-1:DATA_W];
    if (sel_slo) rd_nxt = snap[DATA_W-1:0];
    if (sel_shi) rd_nxt = snap[CNT_W-1:DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_nxt;
  end

  assign rdata = rdata_q;

  assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (rst)
    !sel_any |=> (rdata == '0));
  assert_ctrl_strobes_zero_R2: assert property (@(posedge clk) disable iff (rst)
    sel_ctrl |=> (rdata[DATA_W-1:CB_START] == '0));
endmodule

// File: tb/ivt_timer_bench.sv
module ivt_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  ivt_timer #(.DATA_W(DW), .ADDR_W(AW)) u_ivt_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] last_rd;

  // bench model of the register state
  logic [31:0] m_per = 32'hFFFF_FFFF, m_cnt = 32'hFFFF_FFFF, m_snap = 32'h0;
  logic        m_run = 0, m_to = 0, m_ito = 0, m_cont = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
    case (a)
      5'd0:  return {14'd0, m_run, m_to};
      5'd4:  return {14'd0, m_cont, m_ito};
      5'd8:  return m_per[15:0];
      5'd12: return m_per[31:16];
      5'd16: return m_snap[15:0];
      5'd20: return m_snap[31:16];
      default: return '0;
    endcase
  endfunction

  function automatic string tag_for(input logic [AW-1:0] a);
    case (a)
      5'd0: return "R10";
      5'd4: return "R2";
      5'd8, 5'd12: return "R8";
      5'd16, 5'd20: return "R9";
      default: return "R12";
    endcase
  endfunction

  task automatic model_step(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic tmo;
    logic [31:0] old_cnt;
    tmo = m_run && (m_cnt == 0);
    old_cnt = m_cnt;
    if (m_run) begin
      if (m_cnt == 0) begin m_cnt = m_per; m_run = m_cont; end
      else m_cnt = m_cnt - 1;
    end
    if (tmo) m_to = 1;
    if (wr) begin
      case (a)
        5'd0: if (!tmo) m_to = 0;
        5'd4: begin
          m_ito = d[0]; m_cont = d[1];
          if (d[3]) m_run = 0; else if (d[2]) m_run = 1;
        end
        5'd8:  begin m_per[15:0] = d;  m_cnt = m_per; m_run = 0; end
        5'd12: begin m_per[31:16] = d; m_cnt = m_per; m_run = 0; end
        5'd16: m_snap = old_cnt;
        default: ;
      endcase
    end
  endtask

  // one bus cycle, entered and left at a falling edge
  task automatic cycle(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic chk, input string req);
    logic [DW-1:0] exp_rd;
    wr_en = wr; addr = a; wdata = d;
    exp_rd = model_read(a);
    model_step(wr, a, d);
    @(posedge clk);
    @(negedge clk);
    wr_en = 0;
    last_rd = rdata;
    check("R11 irq", {31'd0, irq}, {31'd0, m_to & m_ito});
    if (chk) check(req, {16'd0, rdata}, {16'd0, exp_rd});
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cycle(1'b1, a, d, 1'b0, "");
  endtask
  task automatic rd(input logic [AW-1:0] a, input string req);
    cycle(1'b0, a, '0, 1'b1, req);
  endtask
  task automatic idle();
    cycle(1'b0, 5'd24, '0, 1'b0, "");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic [31:0] held;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd(5'd0, "R1");  check("R1 status", last_rd, 16'h0);
    rd(5'd4, "R1");  check("R1 control", last_rd, 16'h0);
    rd(5'd8, "R1");  check("R1 period lo", last_rd, 16'hFFFF);
    rd(5'd12, "R1"); check("R1 period hi", last_rd, 16'hFFFF);
    rd(5'd20, "R1"); check("R1 snap hi", last_rd, 16'h0);
    wr(5'd16, 0);
    rd(5'd20, "R1"); check("R1 count hi", last_rd, 16'hFFFF);
    rd(5'd16, "R1"); check("R1 count lo", last_rd, 16'hFFFF);

    // R12 unmapped offsets
    rd(5'd24, "R12"); check("R12 offset 24", last_rd, 16'h0);
    rd(5'd2, "R12");  check("R12 offset 2", last_rd, 16'h0);

    // R3 interval of P+1 cycles, R4 continuous reload
    wr(5'd8, 16'd4);
    wr(5'd12, 16'd0);
    wr(5'd4, 16'h7);
    n = 0;
    while (!irq && n < 100) begin idle(); n++; end
    check("R3 cycles to timeout", n, 5);
    rd(5'd0, "R4"); check("R4 still running", last_rd, 16'h3);
    wr(5'd0, 0);
    rd(5'd0, "R10"); check("R10 flag cleared", last_rd, 16'h2);
    n = 0;
    while (!irq && n < 100) begin idle(); n++; end
    check("R4 second timeout", n, 2);

    // R11 enable gating
    wr(5'd4, 16'h2);
    check("R11 irq off with enable clear", {31'd0, irq}, 32'd0);
    rd(5'd0, "R11"); check("R11 flag kept", {31'd0, last_rd[0]}, 32'd1);
    wr(5'd4, 16'h3);
    check("R11 irq on with enable set", {31'd0, irq}, 32'd1);

    // R7 start and stop together, R2 strobes read 0
    wr(5'd4, 16'hF);
    rd(5'd4, "R2"); check("R2 control readback", last_rd, 16'h3);
    rd(5'd0, "R7"); check("R7 stopped", {31'd0, last_rd[1]}, 32'd0);

    // R8 period write loads count, R6 hold and resume
    wr(5'd0, 0);
    wr(5'd4, 16'h0);
    wr(5'd8, 16'd9);
    wr(5'd16, 0);
    rd(5'd16, "R8"); check("R8 count loaded", last_rd, 16'd9);
    wr(5'd4, 16'h4);
    idle();
    wr(5'd4, 16'h8);
    repeat (3) idle();
    wr(5'd16, 0);
    rd(5'd16, "R6"); check("R6 held count", last_rd, 16'd7);
    wr(5'd4, 16'h4);
    idle();
    wr(5'd16, 0);
    rd(5'd16, "R9"); check("R6 resumed count", last_rd, 16'd6);

    // R5 one-shot
    n = 0;
    do begin rd(5'd0, "R5"); n++; end while (!last_rd[0] && n < 50);
    rd(5'd0, "R5"); check("R5 stopped after timeout", last_rd, 16'h1);
    wr(5'd16, 0);
    rd(5'd16, "R5"); check("R5 count reloaded", last_rd, 16'd9);

    // R8 period write while running
    wr(5'd4, 16'h6);
    repeat (3) idle();
    wr(5'd12, 16'h1);
    rd(5'd0, "R8"); check("R8 stops counter", {31'd0, last_rd[1]}, 32'd0);
    wr(5'd16, 0);
    rd(5'd20, "R8"); check("R8 new count hi", last_rd, 16'h1);
    rd(5'd16, "R8"); check("R8 new count lo", last_rd, 16'h9);

    // R10 clear in the same cycle as a timeout
    wr(5'd8, 16'd0);
    wr(5'd12, 16'd0);
    wr(5'd4, 16'h6);
    idle();
    wr(5'd0, 0);
    rd(5'd0, "R10"); check("R10 timeout wins", {31'd0, last_rd[0]}, 32'd1);
    wr(5'd4, 16'h8);
    wr(5'd0, 0);
    rd(5'd0, "R10"); check("R10 cleared when stopped", last_rd, 16'h0);

    // snapshot holds between captures
    wr(5'd4, 16'h4);
    wr(5'd16, 0);
    held = {16'd0, model_read(5'd16)};
    repeat (4) idle();
    rd(5'd16, "R9"); check("R9 snapshot kept", last_rd, held[15:0]);
    wr(5'd4, 16'h8);

    // constrained random mix against the model
    for (int i = 0; i < 4000; i++) begin
      int unsigned op;
      logic [AW-1:0] a;
      op = $urandom_range(0, 99);
      if (op < 30) begin
        a = AW'(4 * $urandom_range(0, 5));
        rd(a, tag_for(a));
      end else if (op < 36) begin
        a = AW'($urandom_range(0, 31));
        rd(a, tag_for(a));
      end else if (op < 50) begin
        wr(5'd4, DW'($urandom_range(0, 15)));
      end else if (op < 58) begin
        wr(5'd8, DW'($urandom_range(0, 12)));
      end else if (op < 62) begin
        wr(5'd12, ($urandom_range(0, 9) == 0) ? DW'($urandom) : 16'd0);
      end else if (op < 70) begin
        wr(5'd0, DW'($urandom));
      end else if (op < 78) begin
        wr(5'd16, DW'($urandom));
      end else begin
        idle();
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule